// File: doc/BRIEF.md
# Vector Element Mask and Gated Writeback

This block keeps one enable bit for each element position of a vector register, up to the maximum vector length `MVL`. A compare stream fills the mask. Each compare beat carries an element index and a data word, and the mask bit at that index becomes 1 when the word differs bit-for-bit from a broadcast scalar. It becomes 0 when they match. A clear command sets every bit back to 1.

A second stream carries result elements, one per cycle, each tagged with its index. The block registers each element onto a register-file write port. It raises the write enable only when masking is off or when the element's mask bit is 1. An element that is masked off still occupies its cycle: a slot strobe marks every accepted element, so the timing of a masked loop does not depend on the mask contents. The element words are opaque, and no arithmetic is done here.

Top module: `vmask_wb`

## Requirements
- R1: During and after a synchronous active-low reset, `mask_bits` is all ones and `wr_en` and `wr_slot` are 0.
- R2: A compare beat with `cmp_idx < vlen` makes `mask_bits[cmp_idx]` equal to 1 if `cmp_data != scalar` and 0 if they are equal. The new value is visible after the next rising edge.
- R3: A compare beat with `cmp_idx >= vlen` leaves every mask bit unchanged.
- R4: `clr_mask` sets all `MVL` mask bits to 1 at the next edge. When a compare beat arrives in the same cycle, the clear wins.
- R5: An element accepted with `mask_en = 1` whose mask bit is 1 produces, one cycle later, `wr_en = 1` with `wr_idx` and `wr_data` equal to the element's index and word.
- R6: An element accepted with `mask_en = 1` whose mask bit is 0 produces `wr_en = 0` one cycle later, so the register keeps its previous value.
- R7: With `mask_en = 0`, every accepted element is written, whatever the mask holds.
- R8: Every accepted element raises `wr_slot` one cycle later, whether or not it is written. Back-to-back elements give back-to-back slots, and `wr_en` is never 1 outside a slot.
- R9: When an element and a compare, or a clear, touch the same mask bit in the same cycle, the write decision uses the mask bit as it stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| vlen | input | $clog2(MVL)+1 | Current vector length; compares at or above it are dropped |
| scalar | input | DW | Scalar operand for the not-equal compare |
| clr_mask | input | 1 | Set every mask bit to 1 |
| cmp_valid | input | 1 | Compare beat present |
| cmp_idx | input | $clog2(MVL) | Element index of the compare beat |
| cmp_data | input | DW | Element word to compare |
| mask_en | input | 1 | 1: mask gates writes; 0: every element is written |
| elem_valid | input | 1 | Result element present |
| elem_idx | input | $clog2(MVL) | Index of the result element |
| elem_data | input | DW | Result element word |
| wr_en | output | 1 | Register-file write enable |
| wr_slot | output | 1 | An element occupies this writeback cycle |
| wr_idx | output | $clog2(MVL) | Register-file element index |
| wr_data | output | DW | Register-file write data |
| mask_bits | output | MVL | Current mask contents |

## Verification
The hardest case to reach is a single cycle in which a compare or a clear changes the very mask bit that a result element is being gated by. Only that case shows whether the gate reads the old bit or the new one. The stimulus table lines up such cycles on purpose. One row lowers bit 3 by compare while the element for index 3 goes through, and the next row repeats index 3 to show the new bit now blocks it. Another row clears the mask while the element at a cleared-to-zero position is offered. Compares beyond `vlen` are mixed into the same rows, so their lack of effect is read back through `mask_bits` in the same check.

// File: rtl/vmask_pkg.sv
// Package: default sizes shared by the mask and writeback blocks.
// Assumes nothing; holds constants only.
package vmask_pkg;
    localparam int VM_MVL = 8;   // default maximum vector length
    localparam int VM_DW  = 16;  // default element word width
endpackage

// File: rtl/vmask_cmp.sv
// Module: vmask_cmp
// Decodes one compare beat into a per-bit update strobe and the value
// to store. Assumes the caller applies clear priority downstream.
module vmask_cmp #(
    parameter int MVL = 8,
    parameter int DW  = 16,
    localparam int IW = $clog2(MVL),
    localparam int LW = IW + 1
) (
    input  logic           cmp_valid,
    input  logic [IW-1:0]  cmp_idx,
    input  logic [DW-1:0]  cmp_data,
    input  logic [DW-1:0]  scalar,
    input  logic [LW-1:0]  vlen,
    output logic [MVL-1:0] upd_en,
    output logic           upd_val
);
    logic in_range;

    // Accept the beat only below the current vector length.
    always_comb begin
        in_range = cmp_valid && ({1'b0, cmp_idx} < vlen);
        upd_val  = (cmp_data != scalar);
    end

    // One strobe per element position.
    for (genvar g = 0; g < MVL; g++) begin : g_dec
        assign upd_en[g] = in_range && (cmp_idx == IW'(g));
    end

    // R2: at most one mask bit is addressed by a compare beat.
    always_comb begin
        p_single_strobe_r2: assert ($onehot0(upd_en));
    end
endmodule

// File: rtl/vmask_store.sv
// Module: vmask_store
// Holds the MVL-bit mask. Clear has priority over a compare update.
// Assumes upd_en is one-hot or zero.
module vmask_store #(
    parameter int MVL = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic [MVL-1:0] upd_en,
    input  logic           upd_val,
    output logic [MVL-1:0] mask_q
);
    for (genvar g = 0; g < MVL; g++) begin : g_bit
        // Per-bit register: reset and clear to 1, else take the compare result.
        always_ff @(posedge clk) begin
            if (!rst_n)         mask_q[g] <= 1'b1;
            else if (clr)       mask_q[g] <= 1'b1;
            else if (upd_en[g]) mask_q[g] <= upd_val;
        end
    end

    // R1: reset leaves the mask all ones.
    p_reset_ones_r1: assert property (@(posedge clk) !rst_n |=> (&mask_q));

    // R4: a clear leaves the mask all ones on the next cycle.
    p_clear_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (&mask_q));

    // R3: with no clear and no strobe, the mask holds.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && upd_en == '0) |=> $stable(mask_q));
endmodule

// File: rtl/vmask_wbgate.sv
// Module: vmask_wbgate
// Registers one element per cycle onto the write port. The write enable
// is gated by the mask bit sampled before the edge. Every element gets a slot.
module vmask_wbgate #(
    parameter int MVL = 8,
    parameter int DW  = 16,
    localparam int IW = $clog2(MVL)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           elem_valid,
    input  logic [IW-1:0]  elem_idx,
    input  logic [DW-1:0]  elem_data,
    input  logic           mask_en,
    input  logic [MVL-1:0] mask_q,
    output logic           wr_en,
    output logic           wr_slot,
    output logic [IW-1:0]  wr_idx,
    output logic [DW-1:0]  wr_data
);
    logic allow;

    // Write decision from the current (old) mask bit.
    always_comb allow = !mask_en || mask_q[elem_idx];

    // Writeback register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_slot <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en   <= elem_valid && allow;
            wr_slot <= elem_valid;
            wr_idx  <= elem_idx;
            wr_data <= elem_data;
        end
    end

    // R6: a masked-off element is never written.
    p_masked_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_valid && mask_en && !mask_q[elem_idx]) |=> !wr_en);

    // R7: with masking off, an element is always written.
    p_unmasked_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_valid && !mask_en) |=> wr_en);

    // R8: every element takes a slot.
    p_slot_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
        elem_valid |=> wr_slot);

    // R8: a write only ever happens inside a slot.
    p_write_in_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_slot);

    // R5: a written element carries its own index and data.
    p_payload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_valid && allow) |=> (wr_idx == $past(elem_idx) && wr_data == $past(elem_data)));
endmodule

// File: rtl/vmask_wb.sv
// Module: vmask_wb (top)
// Vector mask with not-equal compare fill, clear-to-ones, and gated
// element-serial writeback. Assumes one compare beat and one element per cycle at most.
module vmask_wb
    import vmask_pkg::*;
#(
    parameter int MVL = VM_MVL,
    parameter int DW  = VM_DW,
    localparam int IW = $clog2(MVL),
    localparam int LW = IW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [LW-1:0]  vlen,
    input  logic [DW-1:0]  scalar,
    input  logic           clr_mask,
    input  logic           cmp_valid,
    input  logic [IW-1:0]  cmp_idx,
    input  logic [DW-1:0]  cmp_data,
    input  logic           mask_en,
    input  logic           elem_valid,
    input  logic [IW-1:0]  elem_idx,
    input  logic [DW-1:0]  elem_data,
    output logic           wr_en,
    output logic           wr_slot,
    output logic [IW-1:0]  wr_idx,
    output logic [DW-1:0]  wr_data,
    output logic [MVL-1:0] mask_bits
);
    logic [MVL-1:0] upd_en;
    logic           upd_val;

    vmask_cmp #(.MVL(MVL), .DW(DW)) u_cmp (
        .cmp_valid (cmp_valid),
        .cmp_idx   (cmp_idx),
        .cmp_data  (cmp_data),
        .scalar    (scalar),
        .vlen      (vlen),
        .upd_en    (upd_en),
        .upd_val   (upd_val)
    );

    vmask_store #(.MVL(MVL)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_mask),
        .upd_en  (upd_en),
        .upd_val (upd_val),
        .mask_q  (mask_bits)
    );

    vmask_wbgate #(.MVL(MVL), .DW(DW)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .elem_valid (elem_valid),
        .elem_idx   (elem_idx),
        .elem_data  (elem_data),
        .mask_en    (mask_en),
        .mask_q     (mask_bits),
        .wr_en      (wr_en),
        .wr_slot    (wr_slot),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data)
    );

    // R3: an out-of-range compare without clear leaves the mask untouched.
    p_oob_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && ({1'b0, cmp_idx} >= vlen) && !clr_mask) |=> $stable(mask_bits));

    // R2: an in-range compare stores the not-equal result at its index.
    p_cmp_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && ({1'b0, cmp_idx} < vlen) && !clr_mask)
        |=> (mask_bits[$past(cmp_idx)] == $past(cmp_data != scalar)));
endmodule

// File: tb/test_vmask_wb.sv
module test_vmask_wb;
    localparam int CLK_PERIOD = 10;
    localparam int MVL = 8;
    localparam int DW  = 16;
    localparam logic [DW-1:0] SCAL = 16'h00A5;
    localparam int NROW = 10;

    typedef struct packed {
        logic        cv;
        logic [2:0]  ci;
        logic [15:0] cd;
        logic        clr;
        logic        ev;
        logic [2:0]  ei;
        logic [15:0] ed;
        logic        men;
        logic [3:0]  vl;
        logic        xwen;
        logic [7:0]  xmask;
    } row_t;

    // Stimulus rows with expected write enable and mask after the edge.
    localparam row_t TBL [NROW] = '{
        '{1'b1, 3'd0, 16'h00A5, 1'b0, 1'b0, 3'd0, 16'h0000, 1'b1, 4'd8, 1'b0, 8'hFE}, // R2 equal -> 0
        '{1'b1, 3'd1, 16'h0001, 1'b0, 1'b1, 3'd0, 16'h1111, 1'b1, 4'd8, 1'b0, 8'hFE}, // R2 diff, R6 drop
        '{1'b1, 3'd2, 16'h00A5, 1'b0, 1'b1, 3'd1, 16'h2222, 1'b1, 4'd8, 1'b1, 8'hFA}, // R5 write
        '{1'b1, 3'd5, 16'h00A5, 1'b0, 1'b1, 3'd2, 16'h3333, 1'b0, 4'd4, 1'b1, 8'hFA}, // R3 oob, R7
        '{1'b1, 3'd3, 16'h00A5, 1'b0, 1'b1, 3'd3, 16'h4444, 1'b1, 4'd4, 1'b1, 8'hF2}, // R9 old bit
        '{1'b0, 3'd0, 16'h0000, 1'b0, 1'b1, 3'd3, 16'h5555, 1'b1, 4'd4, 1'b0, 8'hF2}, // R6 new bit
        '{1'b1, 3'd4, 16'h00A5, 1'b1, 1'b1, 3'd2, 16'h6666, 1'b1, 4'd8, 1'b0, 8'hFF}, // R4 prio, R9
        '{1'b0, 3'd0, 16'h0000, 1'b0, 1'b1, 3'd2, 16'h7777, 1'b1, 4'd8, 1'b1, 8'hFF}, // R5 after clear
        '{1'b1, 3'd7, 16'h00A5, 1'b0, 1'b0, 3'd0, 16'h0000, 1'b1, 4'd8, 1'b0, 8'h7F}, // R2 top bit
        '{1'b0, 3'd0, 16'h0000, 1'b0, 1'b1, 3'd7, 16'h9999, 1'b1, 4'd8, 1'b0, 8'h7F}  // R6 top bit
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    vlen = 4'd8;
    logic [DW-1:0] scalar = SCAL;
    logic          clr_mask = 1'b0;
    logic          cmp_valid = 1'b0;
    logic [2:0]    cmp_idx = '0;
    logic [DW-1:0] cmp_data = '0;
    logic          mask_en = 1'b1;
    logic          elem_valid = 1'b0;
    logic [2:0]    elem_idx = '0;
    logic [DW-1:0] elem_data = '0;
    logic          wr_en, wr_slot;
    logic [2:0]    wr_idx;
    logic [DW-1:0] wr_data;
    logic [MVL-1:0] mask_bits;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vmask_wb #(.MVL(MVL), .DW(DW)) i_vmask_wb (
        .clk(clk), .rst_n(rst_n), .vlen(vlen), .scalar(scalar),
        .clr_mask(clr_mask), .cmp_valid(cmp_valid), .cmp_idx(cmp_idx),
        .cmp_data(cmp_data), .mask_en(mask_en), .elem_valid(elem_valid),
        .elem_idx(elem_idx), .elem_data(elem_data), .wr_en(wr_en),
        .wr_slot(wr_slot), .wr_idx(wr_idx), .wr_data(wr_data),
        .mask_bits(mask_bits)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        cmp_valid = 1'b0; elem_valid = 1'b0; clr_mask = 1'b0;
    endtask

    // Apply inputs at the falling edge, then sample a quarter period after the rise.
    task automatic step();
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    initial begin
        // R1: reset state
        @(negedge clk); idle();
        step(); step();
        check("R1", "mask", 32'(mask_bits), 32'hFF);
        check("R1", "wr_en", 32'(wr_en), 32'h0);
        check("R1", "wr_slot", 32'(wr_slot), 32'h0);
        @(negedge clk); rst_n = 1'b1;

        // Table walk (R2..R9)
        for (int r = 0; r < NROW; r++) begin
            @(negedge clk);
            cmp_valid = TBL[r].cv;  cmp_idx = TBL[r].ci;  cmp_data = TBL[r].cd;
            clr_mask = TBL[r].clr;  elem_valid = TBL[r].ev; elem_idx = TBL[r].ei;
            elem_data = TBL[r].ed;  mask_en = TBL[r].men; vlen = TBL[r].vl;
            step();
            check("R2/R3/R4", $sformatf("row %0d mask", r), 32'(mask_bits), 32'(TBL[r].xmask));
            check("R5/R6/R7/R9", $sformatf("row %0d wr_en", r), 32'(wr_en), 32'(TBL[r].xwen));
            check("R8", $sformatf("row %0d wr_slot", r), 32'(wr_slot), 32'(TBL[r].ev));
            if (TBL[r].xwen) begin
                check("R5", $sformatf("row %0d wr_idx", r), 32'(wr_idx), 32'(TBL[r].ei));
                check("R5", $sformatf("row %0d wr_data", r), 32'(wr_data), 32'(TBL[r].ed));
            end
        end

        // R8: back-to-back elements over a mixed mask 8'h7F, one slot per cycle
        for (int k = 4; k < 8; k++) begin
            @(negedge clk);
            idle(); mask_en = 1'b1; vlen = 4'd8;
            elem_valid = 1'b1; elem_idx = 3'(k); elem_data = 16'(16'hA000 + k);
            step();
            check("R8", $sformatf("burst %0d slot", k), 32'(wr_slot), 32'h1);
            check("R6", $sformatf("burst %0d wr_en", k), 32'(wr_en), (k == 7) ? 32'h0 : 32'h1);
        end

        // R3: vlen 0 blocks every compare
        @(negedge clk); idle(); vlen = 4'd0; cmp_valid = 1'b1; cmp_idx = 3'd0; cmp_data = SCAL;
        step();
        check("R3", "vlen0 mask", 32'(mask_bits), 32'h7F);
        check("R8", "idle slot", 32'(wr_slot), 32'h0);

        // R1: reset mid-run restores all ones
        @(negedge clk); idle(); rst_n = 1'b0;
        step();
        check("R1", "mid reset mask", 32'(mask_bits), 32'hFF);
        check("R1", "mid reset wr_en", 32'(wr_en), 32'h0);
        @(negedge clk); rst_n = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule